// File: doc/BRIEF.md
# Clock Gating and Reset Controller

This block derives every clock of a small microcontroller subsystem from one selectable system source and controls, per block, whether that clock runs and whether the block is held in reset. All clocks are modelled as single-cycle enable pulses in one fast reference domain. Three source pulse trains come in: PLL, external crystal and low-speed oscillator. The selected one becomes the system pulse. A bus divider turns it into the bus pulse, which feeds both core clocks and the gated bus-domain outputs: flash interface, GPIO, radio bus interface and DMA. Further dividers fed by the bus pulse produce the register-bus pulse, the radio-domain pulse and one pulse train per peripheral.

Software drives the block through a simple register bus. Gate and reset state is changed only through a set-only word and a clear-only word. A configuration word carries the source select and all divider fields. A fourth word holds the system-tick calibration value and its enable. Dividers apply a new ratio only when the running count wraps, so no period is ever cut short. The parameter NPER (1 to 5) sets the number of peripheral clocks.

Top module: `clkrst_ctrl`

## Requirements
- R1: Configuration offset 0x008 bits [1:0] select the system source: 0 crystal, 1 PLL, 2 low-speed oscillator. A write of code 3 leaves the source unchanged while the other fields of that write still apply. `sys_en` pulses exactly when the selected source pulses.
- R2: The bus pulse is the system pulse divided by (bits [5:2] + 1). `hclk_en` and `fclk_en` pulse on every bus pulse and can never be gated. State bits [1:0] read as 1 and ignore writes.
- R3: `pclk_en` is the bus pulse divided by (bits [9:6] + 1). Every register-bus pulse coincides with a bus pulse.
- R4: Radio code bits [11:10] = 01 divides the bus pulse by 2, and code 10 divides it by 4. A write carrying code 00 or 11 leaves the radio code unchanged.
- R5: Peripheral k runs at the bus pulse divided by (bits [12+4k+3:12+4k] + 1), independently of the other peripherals.
- R6: A write to offset 0x000 sets every state bit written as 1 and leaves the bits written as 0 unchanged. State bit 2+i is the clock gate of block i and bit 16+i is its reset (`blk_rst[i]`). Block order: flash 0, GPIO 1, radio bus 2, DMA 3, register bus 4, radio 5, then peripheral k at 6+k. Reading offset 0x000 or 0x004 returns the state word.
- R7: A write to offset 0x004 clears every state bit written as 1 and leaves the bits written as 0 unchanged.
- R8: A gated output whose gate bit is 0 produces no pulses. The other outputs are unaffected.
- R9: A divider setting change takes effect at the next wrap of the running divider. Successive pulse intervals therefore equal either the old period or the new period.
- R10: Offset 0x00C holds the tick calibration value in bits [23:0] and the tick enable in bit 24. These drive `st_calib` and `st_en` and read back unchanged.
- R11: After reset the source is the crystal and all ratio fields are 0. The radio code is 01. Gates of blocks 0..5 are on and their resets are released. Peripheral gates are off and peripheral resets are asserted. The tick word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | PLL source pulse |
| xtal_tick | input | 1 | Crystal source pulse |
| lsosc_tick | input | 1 | Low-speed oscillator source pulse |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (1 write, 0 read) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| sys_en | output | 1 | System clock pulse |
| hclk_en | output | 1 | Core bus clock pulse (ungated) |
| fclk_en | output | 1 | Core free-running clock pulse (ungated) |
| flash_en | output | 1 | Flash interface clock pulse |
| gpio_en | output | 1 | GPIO clock pulse |
| rbus_en | output | 1 | Radio bus interface clock pulse |
| dma_en | output | 1 | DMA clock pulse |
| pclk_en | output | 1 | Register-bus clock pulse |
| radio_en | output | 1 | Radio-domain clock pulse |
| per_en | output | NPER (4) | Peripheral clock pulses |
| blk_rst | output | NPER+6 (10) | Per-block reset, active high |
| st_calib | output | 24 | Tick calibration value |
| st_en | output | 1 | Tick clock enable |

## Verification
The bench programs six mixes of source and divider settings and counts pulses per output over a window that is a whole multiple of every period used. A wrong ratio, an off-by-one field decode or a swapped source shows up as a count mismatch. It writes a ratio change a few cycles after a bus pulse and checks every pulse interval. A divider that reloads at once would produce a shortened or wrapped interval that is neither 16 nor 4. It clears core gate bits, writes all-zero set and clear words, and writes illegal source and radio codes. A design that honoured any of these would stop the core pulses, alter the state word or change a pulse rate. Gated outputs are counted while gated, to catch a gate applied to the wrong block.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  localparam int DW       = 32;
  localparam int NFIX     = 6;   // bus-domain and fixed gated blocks
  localparam int B_FLASH  = 0;
  localparam int B_GPIO   = 1;
  localparam int B_RBUS   = 2;
  localparam int B_DMA    = 3;
  localparam int B_REGB   = 4;
  localparam int B_RADIO  = 5;
  localparam int GATE_LSB = 2;
  localparam int RST_LSB  = 16;
  localparam int F_SRC    = 0;
  localparam int F_BUS    = 2;
  localparam int F_REG    = 6;
  localparam int F_RAD    = 10;
  localparam int F_PER    = 12;
  localparam int FW       = 4;   // divider field width
  localparam int RW       = FW + 1;
  localparam int TW       = 25;  // tick word width
  localparam int OFS_SET  = 'h000;
  localparam int OFS_CLR  = 'h004;
  localparam int OFS_CFG  = 'h008;
  localparam int OFS_TICK = 'h00C;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_LSO  = 2'd2
  } src_e;

  localparam logic [1:0] RAD_FAST = 2'b01;
  localparam logic [1:0] RAD_SLOW = 2'b10;

  function automatic logic [RW-1:0] field_ratio(input logic [FW-1:0] f);
    return RW'(f) + RW'(1);
  endfunction

  function automatic logic [RW-1:0] radio_ratio(input logic [1:0] c);
    return (c == RAD_SLOW) ? RW'(4) : RW'(2);
  endfunction

  function automatic logic radio_legal(input logic [1:0] c);
    return (c == RAD_FAST) || (c == RAD_SLOW);
  endfunction

  function automatic logic src_legal(input logic [1:0] c);
    return c != 2'b11;
  endfunction
endpackage

// File: rtl/clkrst_div.sv
module clkrst_div
  import clkrst_pkg::*;
#(
  parameter logic [RW-1:0] RST_RATIO = RW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [RW-1:0] ratio_i,
  output logic          tick_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] act_q;
  logic          wrap;

  assign wrap   = (cnt_q == act_q - RW'(1));
  assign tick_o = tick_i & wrap;

  // ratio is reloaded only on a wrap so the running period is never cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RST_RATIO;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        act_q <= ratio_i;
      end else begin
        cnt_q <= cnt_q + RW'(1);
      end
    end
  end
endmodule

// File: rtl/clkrst_regs.sv
module clkrst_regs
  import clkrst_pkg::*;
#(
  parameter int NPER   = 4,
  parameter int ADDR_W = 12,
  localparam int NBLK  = NFIX + NPER
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NBLK-1:0]    gate_o,
  output logic [NBLK-1:0]    rst_o,
  output logic [1:0]         src_o,
  output logic [FW-1:0]      busf_o,
  output logic [FW-1:0]      regf_o,
  output logic [1:0]         radio_o,
  output logic [NPER*FW-1:0] perf_o,
  output logic [TW-1:0]      tick_o
);
  localparam logic [NBLK-1:0] GATE_RST = NBLK'((1 << NFIX) - 1);
  localparam logic [NBLK-1:0] RSTB_RST = ~GATE_RST;

  logic [NBLK-1:0]    gate_q, rst_q;
  logic [1:0]         src_q, radio_q;
  logic [FW-1:0]      busf_q, regf_q;
  logic [NPER*FW-1:0] perf_q;
  logic [TW-1:0]      tick_q;
  logic               wr_set, wr_clr, wr_cfg, wr_tick;
  logic [DW-1:0]      state_w, cfg_w;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_set  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_SET));
  assign wr_clr  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_cfg  = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_tick = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_TICK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= GATE_RST;
      rst_q  <= RSTB_RST;
    end else if (wr_set) begin
      gate_q <= gate_q | bus_wdata[GATE_LSB +: NBLK];
      rst_q  <= rst_q  | bus_wdata[RST_LSB  +: NBLK];
    end else if (wr_clr) begin
      gate_q <= gate_q & ~bus_wdata[GATE_LSB +: NBLK];
      rst_q  <= rst_q  & ~bus_wdata[RST_LSB  +: NBLK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_XTAL;
      busf_q  <= '0;
      regf_q  <= '0;
      radio_q <= RAD_FAST;
      perf_q  <= '0;
    end else if (wr_cfg) begin
      if (src_legal(bus_wdata[F_SRC +: 2])) src_q <= bus_wdata[F_SRC +: 2];
      if (radio_legal(bus_wdata[F_RAD +: 2])) radio_q <= bus_wdata[F_RAD +: 2];
      busf_q <= bus_wdata[F_BUS +: FW];
      regf_q <= bus_wdata[F_REG +: FW];
      perf_q <= bus_wdata[F_PER +: NPER*FW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (wr_tick) tick_q <= bus_wdata[TW-1:0];
  end

  always_comb begin
    state_w = '0;
    state_w[1:0] = 2'b11;  // core clocks: always running
    state_w[GATE_LSB +: NBLK] = gate_q;
    state_w[RST_LSB  +: NBLK] = rst_q;
    cfg_w = '0;
    cfg_w[F_SRC +: 2]        = src_q;
    cfg_w[F_BUS +: FW]       = busf_q;
    cfg_w[F_REG +: FW]       = regf_q;
    cfg_w[F_RAD +: 2]        = radio_q;
    cfg_w[F_PER +: NPER*FW]  = perf_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_W'(OFS_SET), ADDR_W'(OFS_CLR): bus_rdata = state_w;
        ADDR_W'(OFS_CFG):                   bus_rdata = cfg_w;
        ADDR_W'(OFS_TICK):                  bus_rdata = DW'(tick_q);
        default:                            bus_rdata = '0;
      endcase
    end
  end

  assign gate_o  = gate_q;
  assign rst_o   = rst_q;
  assign src_o   = src_q;
  assign busf_o  = busf_q;
  assign regf_o  = regf_q;
  assign radio_o = radio_q;
  assign perf_o  = perf_q;
  assign tick_o  = tick_q;
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
  import clkrst_pkg::*;
#(
  parameter int NPER   = 4,
  parameter int ADDR_W = 12,
  localparam int NBLK  = NFIX + NPER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_tick,
  input  logic              xtal_tick,
  input  logic              lsosc_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_en,
  output logic              hclk_en,
  output logic              fclk_en,
  output logic              flash_en,
  output logic              gpio_en,
  output logic              rbus_en,
  output logic              dma_en,
  output logic              pclk_en,
  output logic              radio_en,
  output logic [NPER-1:0]   per_en,
  output logic [NBLK-1:0]   blk_rst,
  output logic [23:0]       st_calib,
  output logic              st_en
);
  logic [NBLK-1:0]    gate;
  logic [1:0]         src_code, radio_code;
  logic [FW-1:0]      busf, regf;
  logic [NPER*FW-1:0] perf;
  logic [TW-1:0]      tick_word;
  logic               sys_tick, bus_tick, reg_tick, rad_tick;
  logic [NPER-1:0]    per_tick;

  clkrst_regs #(.NPER(NPER), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gate_o(gate), .rst_o(blk_rst), .src_o(src_code),
    .busf_o(busf), .regf_o(regf), .radio_o(radio_code),
    .perf_o(perf), .tick_o(tick_word)
  );

  always_comb begin
    case (src_code)
      SRC_PLL: sys_tick = pll_tick;
      SRC_LSO: sys_tick = lsosc_tick;
      default: sys_tick = xtal_tick;
    endcase
  end

  clkrst_div #(.RST_RATIO(RW'(1))) u_bus_div (
    .clk(clk), .rst_n(rst_n), .tick_i(sys_tick),
    .ratio_i(field_ratio(busf)), .tick_o(bus_tick)
  );

  clkrst_div #(.RST_RATIO(RW'(1))) u_reg_div (
    .clk(clk), .rst_n(rst_n), .tick_i(bus_tick),
    .ratio_i(field_ratio(regf)), .tick_o(reg_tick)
  );

  clkrst_div #(.RST_RATIO(RW'(2))) u_rad_div (
    .clk(clk), .rst_n(rst_n), .tick_i(bus_tick),
    .ratio_i(radio_ratio(radio_code)), .tick_o(rad_tick)
  );

  for (genvar k = 0; k < NPER; k++) begin : g_per
    clkrst_div #(.RST_RATIO(RW'(1))) u_per_div (
      .clk(clk), .rst_n(rst_n), .tick_i(bus_tick),
      .ratio_i(field_ratio(perf[k*FW +: FW])), .tick_o(per_tick[k])
    );
    assign per_en[k] = per_tick[k] & gate[NFIX + k];
  end

  assign sys_en   = sys_tick;
  assign hclk_en  = bus_tick;
  assign fclk_en  = bus_tick;
  assign flash_en = bus_tick & gate[B_FLASH];
  assign gpio_en  = bus_tick & gate[B_GPIO];
  assign rbus_en  = bus_tick & gate[B_RBUS];
  assign dma_en   = bus_tick & gate[B_DMA];
  assign pclk_en  = reg_tick & gate[B_REGB];
  assign radio_en = rad_tick & gate[B_RADIO];
  assign st_calib = tick_word[23:0];
  assign st_en    = tick_word[24];
endmodule

// File: rtl/clkrst_ctrl_chk.sv
module clkrst_ctrl_chk
  import clkrst_pkg::*;
#(
  parameter int NPER   = 4,
  parameter int ADDR_W = 12,
  localparam int NBLK  = NFIX + NPER
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pll_tick,
  input logic              xtal_tick,
  input logic              lsosc_tick,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sys_en,
  input logic              hclk_en,
  input logic              fclk_en,
  input logic              flash_en,
  input logic              gpio_en,
  input logic              rbus_en,
  input logic              dma_en,
  input logic              pclk_en,
  input logic              radio_en,
  input logic [NPER-1:0]   per_en,
  input logic [NBLK-1:0]   blk_rst,
  input logic [1:0]        src_code,
  input logic [1:0]        radio_code
);
  logic wr_set, wr_clr, wr_cfg;
  assign wr_set = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_SET));
  assign wr_clr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_cfg = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CFG));

  assert_sys_from_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en |-> (pll_tick || xtal_tick || lsosc_tick));

  assert_src_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && bus_wdata[F_SRC +: 2] == 2'b11) |=> $stable(src_code));

  assert_core_with_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_en || gpio_en || rbus_en || dma_en) |-> (hclk_en && fclk_en));

  assert_regbus_in_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |-> hclk_en);

  assert_radio_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_code == RAD_FAST) || (radio_code == RAD_SLOW));

  assert_radio_in_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    radio_en |-> hclk_en);

  assert_set_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && bus_wdata[RST_LSB]) |=> blk_rst[0]);

  assert_clear_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[RST_LSB]) |=> !blk_rst[0]);

  assert_cleared_gate_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[GATE_LSB + NFIX]) |=> !per_en[0]);
endmodule

bind clkrst_ctrl clkrst_ctrl_chk #(.NPER(NPER), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pll_tick(pll_tick), .xtal_tick(xtal_tick), .lsosc_tick(lsosc_tick),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sys_en(sys_en), .hclk_en(hclk_en), .fclk_en(fclk_en),
  .flash_en(flash_en), .gpio_en(gpio_en), .rbus_en(rbus_en), .dma_en(dma_en),
  .pclk_en(pclk_en), .radio_en(radio_en), .per_en(per_en), .blk_rst(blk_rst),
  .src_code(src_code), .radio_code(radio_code)
);

// File: tb/clkrst_ctrl_tb.sv
module clkrst_ctrl_tb;
  localparam int NPER = 4;
  localparam int NBLK = 6 + NPER;
  localparam int WIN  = 1920;
  localparam int SETTLE = 800;
  localparam int NV = 6;
  // {exp_bus[16], exp_reg[16], src, bus ratio, reg ratio, radio code, p0, p1, p2, p3}
  localparam logic [95:0] VEC [NV] = '{
    {16'd1920, 16'd1920, 8'd0, 8'd1,  8'd1, 8'd1, 8'd1, 8'd2, 8'd3, 8'd4},
    {16'd960,  16'd240,  8'd0, 8'd2,  8'd4, 8'd2, 8'd5, 8'd6, 8'd8, 8'd16},
    {16'd320,  16'd160,  8'd1, 8'd3,  8'd2, 8'd1, 8'd1, 8'd5, 8'd4, 8'd2},
    {16'd240,  16'd120,  8'd2, 8'd1,  8'd2, 8'd2, 8'd3, 8'd1, 8'd2, 8'd4},
    {16'd120,  16'd120,  8'd0, 8'd16, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
    {16'd192,  16'd64,   8'd1, 8'd5,  8'd3, 8'd3, 8'd2, 8'd3, 8'd4, 8'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sys_en, hclk_en, fclk_en, flash_en, gpio_en, rbus_en, dma_en, pclk_en, radio_en;
  logic [NPER-1:0] per_en;
  logic [NBLK-1:0] blk_rst;
  logic [23:0] st_calib;
  logic st_en;
  logic [7:0] tcnt = '0;
  logic pll_tick, xtal_tick, lsosc_tick;

  int checks = 0, fails = 0;
  bit done = 0;
  bit cnt_on = 0, mon_on = 0, seen = 0;
  int c_sys, c_h, c_f, c_p, c_r, c_flash, gap, n16, n4, nbad;
  int c_per [NPER];

  always #2 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 8'd1;
  assign xtal_tick  = 1'b1;
  assign pll_tick   = tcnt[0];
  assign lsosc_tick = (tcnt[2:0] == 3'd0);

  clkrst_ctrl #(.NPER(NPER), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .lsosc_tick(lsosc_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_en(sys_en), .hclk_en(hclk_en), .fclk_en(fclk_en), .flash_en(flash_en),
    .gpio_en(gpio_en), .rbus_en(rbus_en), .dma_en(dma_en), .pclk_en(pclk_en),
    .radio_en(radio_en), .per_en(per_en), .blk_rst(blk_rst),
    .st_calib(st_calib), .st_en(st_en)
  );

  always @(negedge clk) begin
    if (cnt_on) begin
      c_sys += int'(sys_en); c_h += int'(hclk_en); c_f += int'(fclk_en);
      c_p += int'(pclk_en); c_r += int'(radio_en); c_flash += int'(flash_en);
      for (int k = 0; k < NPER; k++) c_per[k] += int'(per_en[k]);
    end
    if (mon_on) begin
      gap++;
      if (hclk_en) begin
        if (seen) begin
          if (gap == 16) n16++;
          else if (gap == 4) n4++;
          else nbad++;
        end
        seen = 1; gap = 0;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic measure();
    @(negedge clk);
    c_sys = 0; c_h = 0; c_f = 0; c_p = 0; c_r = 0; c_flash = 0;
    for (int k = 0; k < NPER; k++) c_per[k] = 0;
    cnt_on = 1;
    repeat (WIN) @(negedge clk);
    cnt_on = 0;
  endtask

  function automatic int src_period(input int s);
    return (s == 1) ? 2 : (s == 2) ? 8 : 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all requirements: watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int rad_code, sp, bp;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd(12'h000, d); check("R11 state word", d, 32'h03C0_00FF);
    rd(12'h004, d); check("R11 state via clear offset", d, 32'h03C0_00FF);
    rd(12'h008, d); check("R11 config word", d, 32'h0000_0400);
    rd(12'h00C, d); check("R11 tick word", d, 0);
    check("R11 blk_rst", blk_rst, 10'h3C0);
    check("R11 st_en", st_en, 0);
    measure();
    check("R11 sys count", c_sys, WIN);
    check("R11 hclk count", c_h, WIN);
    check("R11 radio count", c_r, WIN / 2);
    check("R11 flash count", c_flash, WIN);
    for (int k = 0; k < NPER; k++) check("R8 R11 peripheral gated off", c_per[k], 0);

    // R6 set / R7 clear
    wr(12'h000, 32'h0000_0F00);
    rd(12'h000, d); check("R6 set peripheral gates", d, 32'h03C0_0FFF);
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R6 zero write no effect", d, 32'h03C0_0FFF);
    wr(12'h004, 32'h03C0_0000);
    rd(12'h004, d); check("R7 clear peripheral resets", d, 32'h0000_0FFF);
    check("R7 blk_rst released", blk_rst, 0);
    wr(12'h004, 32'h0);
    rd(12'h000, d); check("R7 zero write no effect", d, 32'h0000_0FFF);
    wr(12'h000, 32'h0001_0000);
    check("R6 flash reset asserted", blk_rst, 10'h001);
    wr(12'h004, 32'h0001_0000);
    check("R7 flash reset released", blk_rst, 0);

    // table walk: R1 R2 R3 R4 R5
    rad_code = 1;
    for (int v = 0; v < NV; v++) begin
      logic [95:0] e;
      logic [31:0] cfg;
      int pr [NPER];
      e = VEC[v];
      for (int k = 0; k < NPER; k++) pr[k] = int'(e[31 - 8*k -: 8]);
      cfg = 32'(e[63:56]) | (32'(e[55:48] - 8'd1) << 2) | (32'(e[47:40] - 8'd1) << 6)
          | (32'(e[39:32]) << 10);
      for (int k = 0; k < NPER; k++) cfg |= 32'(pr[k] - 1) << (12 + 4*k);
      if (e[39:32] == 8'd1 || e[39:32] == 8'd2) rad_code = int'(e[39:32]);
      wr(12'h008, cfg);
      repeat (SETTLE) @(negedge clk);
      measure();
      sp = src_period(int'(e[63:56]));
      bp = sp * int'(e[55:48]);
      check($sformatf("R1 sys count v%0d", v), c_sys, WIN / sp);
      check($sformatf("R2 hclk count v%0d", v), c_h, int'(e[95:80]));
      check($sformatf("R2 fclk count v%0d", v), c_f, WIN / bp);
      check($sformatf("R3 pclk count v%0d", v), c_p, int'(e[79:64]));
      check($sformatf("R4 radio count v%0d", v), c_r, WIN / (bp * (rad_code == 2 ? 4 : 2)));
      for (int k = 0; k < NPER; k++)
        check($sformatf("R5 per%0d count v%0d", k, v), c_per[k], WIN / (bp * pr[k]));
    end

    // R2 core gate bits ignore clears
    wr(12'h004, 32'h0000_0003);
    rd(12'h000, d); check("R2 core bits read 1", d[1:0], 2'b11);
    measure();
    check("R2 hclk still running", c_h, 192);
    check("R2 fclk still running", c_f, 192);

    // R8 gated outputs silent
    wr(12'h004, 32'h0000_0180);
    measure();
    check("R8 per0 silent", c_per[0], 0);
    check("R8 radio silent", c_r, 0);
    check("R8 per1 unaffected", c_per[1], WIN / 30);
    check("R8 hclk unaffected", c_h, 192);
    wr(12'h000, 32'h0000_0180);

    // R1 illegal source code rejected (also R4 illegal radio code 00)
    wr(12'h008, 32'h0000_0003 | (32'd4 << 2) | (32'd2 << 6) | (32'd0 << 10));
    rd(12'h008, d);
    check("R1 src kept", d[1:0], 2'b01);
    check("R4 radio code kept", d[11:10], 2'b01);
    repeat (SETTLE) @(negedge clk);
    measure();
    check("R1 sys still PLL", c_sys, WIN / 2);
    check("R2 bus ratio applied with rejected src", c_h, WIN / 10);

    // R9 divider change only at wrap
    wr(12'h008, (32'd15 << 2) | (32'd1 << 10));
    repeat (600) @(negedge clk);
    n16 = 0; n4 = 0; nbad = 0; seen = 0; gap = 0;
    mon_on = 1;
    repeat (100) @(negedge clk);
    do @(negedge clk); while (!hclk_en);
    repeat (6) @(negedge clk);
    wr(12'h008, (32'd3 << 2) | (32'd1 << 10));
    repeat (200) @(negedge clk);
    mon_on = 0;
    check("R9 no shortened interval", nbad, 0);
    check("R9 old period seen", n16 > 0, 1);
    check("R9 new period seen", n4 > 0, 1);

    // R10 tick word
    wr(12'h00C, 32'h01AB_CDEF);
    check("R10 calib", st_calib, 24'hABCDEF);
    check("R10 enable", st_en, 1);
    rd(12'h00C, d); check("R10 readback", d, 32'h01AB_CDEF);
    wr(12'h00C, 32'h0012_3456);
    check("R10 enable off", st_en, 0);
    check("R10 calib 2", st_calib, 24'h123456);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule